// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port behind a simple byte-wide register bus. Software picks, line by line, whether each pin is driven or sampled. The block drives output values and output enables to the pads and passes the input pads through a two-stage synchroniser before software can read them.

Pin data is reached through a data window in the lower half of the address space. Address bits [9:2] form a per-access line mask. A write changes only the lines whose mask bit is set. A read returns zeros in every unmasked position. Software can therefore set or sample any subset of lines in a single access, without a read-modify-write and without races against other users of the port. The bus has no back-pressure. Every strobe is accepted in the cycle it is presented. A write lands on the clock edge that ends the strobe cycle, and read data is returned combinationally in the same cycle.

Top module: `gpio_masked_port`

## Requirements
- R1: After a synchronous active-low reset, the direction register, the output data, `pad_oe` and `pad_out` are all zero. The direction register reads back as 0x00 at offset 0x400.
- R2: A write to offset 0x400 loads the direction register on the edge that ends the strobe cycle (bit value 1 = output, 0 = input). `pad_oe` equals the direction register, and a read of 0x400 returns it.
- R3: A write to the data window (offsets 0x000 to 0x3FC, address bit 10 = 0, bits [1:0] = 0) updates output bit n from `bus_wdata[n]` only when address bit n+2 is set and line n is an output. All other output bits keep their values.
- R4: A window write to a line configured as input leaves that line's output value unchanged. The value does not appear on `pad_out`, even after the line is later switched to output.
- R5: A window read returns zero in every bit position whose mask bit (address bit n+2) is clear.
- R6: For a masked bit of a window read, the result is the output value when the line is an output, and the synchronised pad value when the line is an input.
- R7: A change on `pad_in` becomes visible to window reads after exactly two rising clock edges.
- R8: `bus_rdata` is valid in the same cycle as a read strobe (`bus_sel`=1, `bus_wr`=0). It is zero whenever no read strobe is present.
- R9: Writes to unmapped offsets have no effect on direction or output data, and reads from them return zero. Unmapped offsets are any offset with bit 10 set other than 0x400, and any window offset with bits [1:0] nonzero.
- R10: A window write does not alter the direction register. A direction write does not alter the output data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle as the strobe |
| pad_in | input | 8 | Asynchronous input pad values |
| pad_out | output | 8 | Output values to the pads |
| pad_oe | output | 8 | Output enables to the pads (1 = drive) |

## Verification
The assertions assume that the bus inputs change only between clock edges and that each strobe describes a single complete access in its own cycle. The synchroniser check also assumes that `pad_in` carries known values from reset onward. The bench drives every strobe, address and pad value on the falling edge and holds the pads at zero during reset. It sweeps all 256 line masks for writes and reads against several direction patterns. Expected pad and read values come from a bench-side arithmetic model of the mask, direction and pad data.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // Which register an access selects
  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_WINDOW = 2'd1,
    REG_DIR    = 2'd2
  } gpio_reg_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int LINES = 8,
  localparam int AW = LINES + 3
) (
  input  logic [AW-1:0]    addr,
  output gpio_reg_e        region,
  output logic [LINES-1:0] line_mask
);
  localparam logic [AW-1:0] DIR_OFS = AW'(1) << (LINES + 2);

  always_comb begin
    line_mask = addr[LINES+1:2];
    region    = REG_NONE;
    if (!addr[AW-1]) begin
      if (addr[1:0] == 2'b00) region = REG_WINDOW;
    end else if (addr == DIR_OFS) begin
      region = REG_DIR;
    end
  end
endmodule

// File: rtl/gpio_line_bank.sv
module gpio_line_bank
  import gpio_port_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  gpio_reg_e        region,
  input  logic [LINES-1:0] line_mask,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] dir_q,
  output logic [LINES-1:0] out_q
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_q[i] <= 1'b0;
        out_q[i] <= 1'b0;
      end else if (wr_en) begin
        if (region == REG_DIR)
          dir_q[i] <= wdata[i];
        if (region == REG_WINDOW && line_mask[i] && dir_q[i])
          out_q[i] <= wdata[i];
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int LINES  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [LINES-1:0] async_in,
  output logic [LINES-1:0] sync_out
);
  logic [LINES-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) stage_q[0] <= async_in;
    end else begin : g_next
      always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_port_pkg::*;
#(
  parameter int LINES = 8,
  localparam int AW = LINES + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] bus_rdata,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe
);
  gpio_reg_e        region;
  logic [LINES-1:0] line_mask;
  logic [LINES-1:0] dir_q;
  logic [LINES-1:0] out_q;
  logic [LINES-1:0] pin_sync;
  logic             wr_en;
  logic             rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  gpio_addr_decode #(.LINES(LINES)) u_dec (
    .addr      (bus_addr),
    .region    (region),
    .line_mask (line_mask)
  );

  gpio_line_bank #(.LINES(LINES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .region    (region),
    .line_mask (line_mask),
    .wdata     (bus_wdata),
    .dir_q     (dir_q),
    .out_q     (out_q)
  );

  gpio_in_sync #(.LINES(LINES), .STAGES(2)) u_sync (
    .clk      (clk),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (region)
        REG_WINDOW: bus_rdata = line_mask & ((dir_q & out_q) | (~dir_q & pin_sync));
        REG_DIR:    bus_rdata = dir_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int LINES = 8,
  localparam int AW = LINES + 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [LINES-1:0] bus_wdata,
  input logic [LINES-1:0] bus_rdata,
  input logic [LINES-1:0] pad_in,
  input logic [LINES-1:0] pad_out,
  input logic [LINES-1:0] pad_oe
);
  localparam logic [AW-1:0] DIR_OFS = AW'(1) << (LINES + 2);

  logic win_acc;
  logic dir_acc;
  logic [LINES-1:0] msk;
  assign win_acc = bus_sel && !bus_addr[AW-1] && bus_addr[1:0] == 2'b00;
  assign dir_acc = bus_sel && bus_addr == DIR_OFS;
  assign msk     = bus_addr[LINES+1:2];

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pad_oe == '0 && pad_out == '0));

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_acc && bus_wr) |=> pad_oe == $past(bus_wdata));

  // R3
  masked_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && bus_wr) |=>
      ((pad_out ^ $past(pad_out)) & ~($past(msk) & $past(pad_oe))) == '0);

  // R3
  masked_write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && bus_wr) |=>
      (pad_out & $past(msk) & $past(pad_oe)) == ($past(bus_wdata) & $past(msk) & $past(pad_oe)));

  // R5
  read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && !bus_wr) |-> (bus_rdata & ~msk) == '0);

  // R7
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && !bus_wr && msk == '1 && pad_oe == '0 && $past(rst_n) && $past(rst_n, 2))
      |-> bus_rdata == $past(pad_in, 2));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |-> bus_rdata == '0);

  // R10
  window_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && bus_wr) |=> $stable(pad_oe));

  // R10
  dir_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_acc && bus_wr) |=> $stable(pad_out));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !win_acc && !dir_acc) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_masked_port gpio_port_checker #(.LINES(LINES)) u_chk (.*);

// File: tb/sim_gpio_masked_port.sv
`timescale 1ns/1ps
module sim_gpio_masked_port;
  localparam logic [10:0] DIR_A = 11'h400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  gpio_masked_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  function automatic logic [10:0] win(input logic [7:0] m);
    return {1'b0, m, 2'b00};
  endfunction

  logic [7:0] m_dir, m_out, m_pin, rd, wd, mk;
  logic [7:0] dirs [4];

  initial begin
    dirs[0] = 8'h00; dirs[1] = 8'hFF; dirs[2] = 8'h5A; dirs[3] = 8'hC3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    bus_read(DIR_A, rd);
    chk("R1 dir read", rd, 8'h00);
    m_dir = 8'h00; m_out = 8'h00;

    // R8 no strobe -> zero
    #1 chk("R8 idle rdata", bus_rdata, 8'h00);

    // R4 write to input lines, then switch to output
    bus_write(win(8'hFF), 8'hFF);
    chk("R4 pad_out unchanged", pad_out, 8'h00);
    bus_write(DIR_A, 8'hFF);
    chk("R4 pad_out after dir", pad_out, 8'h00);
    chk("R2 pad_oe", pad_oe, 8'hFF);
    bus_read(DIR_A, rd);
    chk("R2 dir read", rd, 8'hFF);
    m_dir = 8'hFF;

    // R10 dir write keeps out, window write keeps dir
    bus_write(win(8'hFF), 8'hA5);
    m_out = 8'hA5;
    bus_write(DIR_A, 8'h0F);
    chk("R10 out kept on dir write", pad_out, 8'hA5);
    bus_write(win(8'hFF), 8'h3C);
    chk("R10 dir kept on window write", pad_oe, 8'h0F);
    m_dir = 8'h0F; m_out = (m_out & 8'hF0) | (8'h3C & 8'h0F);

    // R3 R4 sweep: every mask under several direction patterns
    for (int k = 0; k < 4; k++) begin
      bus_write(DIR_A, dirs[k]);
      m_dir = dirs[k];
      chk("R2 sweep pad_oe", pad_oe, m_dir);
      for (int m = 0; m < 256; m++) begin
        mk = 8'(m);
        wd = 8'(m * 29) ^ 8'h6B ^ dirs[k];
        bus_write(win(mk), wd);
        m_out = (m_out & ~(mk & m_dir)) | (wd & mk & m_dir);
        chk("R3 R4 masked write", pad_out, m_out);
      end
    end

    // R7 synchroniser latency
    bus_write(DIR_A, 8'h00);
    m_dir = 8'h00;
    @(negedge clk); pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'hA5;
    bus_read(win(8'hFF), rd);
    chk("R7 after one edge", rd, 8'h00);
    bus_read(win(8'hFF), rd);
    chk("R7 after two edges", rd, 8'hA5);

    // R5 R6 read sweep over all masks
    for (int k = 0; k < 4; k++) begin
      bus_write(DIR_A, dirs[k]);
      m_dir = dirs[k];
      bus_write(win(8'hFF), 8'h96 ^ dirs[k]);
      m_out = (m_out & ~m_dir) | ((8'h96 ^ dirs[k]) & m_dir);
      @(negedge clk);
      m_pin = 8'h3C + 8'(k * 71);
      pad_in = m_pin;
      repeat (3) @(negedge clk);
      for (int m = 0; m < 256; m++) begin
        mk = 8'(m);
        bus_read(win(mk), rd);
        chk("R5 R6 masked read", rd, mk & ((m_dir & m_out) | (~m_dir & m_pin)));
      end
    end

    // R9 unmapped offsets
    bus_write(11'h404, 8'hFF);
    bus_write(11'h7FC, 8'h00);
    bus_write(11'h001, 8'h00);
    bus_write(11'h3FE, ~m_out);
    chk("R9 pad_oe", pad_oe, m_dir);
    chk("R9 pad_out", pad_out, m_out);
    bus_read(11'h404, rd);
    chk("R9 read 404", rd, 8'h00);
    bus_read(11'h3FD, rd);
    chk("R9 read misaligned", rd, 8'h00);

    // R8 write strobe leaves rdata zero
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = DIR_A; bus_wdata = m_dir;
    #1 chk("R8 rdata on write", bus_rdata, 8'h00);
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;

    // R1 reset again clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 reset pad_oe", pad_oe, 8'h00);
    chk("R1 reset pad_out", pad_out, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule